// File: doc/BRIEF.md
# Shared-Bus Direction Switch for a Half-Duplex Converter Port

This block lets one 12-bit data bus, one qualifier line and one clock line serve both a transmit path and a receive path. At any moment the bus points one way. In the receive direction the block sources the bus: it registers the receive data and qualifier onto the shared lines and enables their drivers. In the transmit direction it releases the drivers and hands the inbound bus contents to the transmit datapath. In the receive direction the transmit side sees zeros.

The direction comes from one of two places. An external level pin can set it, and that pin is synchronized first. A configuration bit can also set it, and that bit is already in the core clock domain. A select bit chooses which of the two is obeyed.

Clock routing depends on a one-clock or two-clock arrangement:

- **One-clock:** the shared clock line carries the receive clock or the transmit clock, whichever direction is active.
- **Two-clock:** the shared clock line only ever carries the receive clock, and the transmit clock has its own pin.

By default each locally sourced clock is silenced while its direction is idle. An override bit keeps both clocks running.

Top module: `hdx_port_mux`

## Requirements
- R1: While `rst_n` is low, and immediately after it rises, the direction is receive (`dir_is_tx`=0). The data and qualifier enables are high. `tx_data` and `tx_qual` are 0.
- R2: With `cfg_dir_src`=1, `dir_is_tx` takes the value `cfg_dir_tx` had at the previous clock edge (1 means transmit).
- R3: With `cfg_dir_src`=0, `dir_is_tx` follows `dir_pin` (1 means transmit) on the third clock edge after the pin changes. While this source is selected, `cfg_dir_tx` has no effect.
- R4: `trx_d_out` and `trx_q_out` equal `rx_data` and `rx_qual` delayed by one clock.
- R5: In the transmit direction, `tx_data` and `tx_qual` equal `trx_d_in` and `trx_q_in` in the same cycle. In the receive direction both are 0.
- R6: `trx_d_oe` and `trx_q_oe` are high only in the receive direction. Both are low in the first cycle after `dir_is_tx` changes value, in either direction.
- R7: With `cfg_two_clk`=0, `trx_clk_out` follows `rx_clk_src` in the receive direction and `tx_clk_src` in the transmit direction. `txclk_pin_out` stays 0.
- R8: With `cfg_two_clk`=1, `trx_clk_out` only ever carries `rx_clk_src`, and `txclk_pin_out` carries `tx_clk_src`.
- R9: With `cfg_clk_keep`=0, the receive clock is forced to 0 in the transmit direction, and the transmit clock is forced to 0 in the receive direction.
- R10: With `cfg_clk_keep`=1, neither clock is forced to 0, whatever the direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_pin | input | 1 | Asynchronous direction pin, 1 = transmit |
| cfg_dir_src | input | 1 | Direction source select: 0 = pin, 1 = register bit |
| cfg_dir_tx | input | 1 | Register direction bit, 1 = transmit |
| cfg_two_clk | input | 1 | 1 = two-clock arrangement, 0 = one-clock |
| cfg_clk_keep | input | 1 | 1 = keep both sourced clocks running |
| rx_data | input | 12 | Receive datapath output word |
| rx_qual | input | 1 | Receive datapath qualifier |
| rx_clk_src | input | 1 | Locally sourced receive clock |
| tx_clk_src | input | 1 | Locally sourced transmit clock |
| trx_d_in | input | 12 | Shared data bus, inbound side |
| trx_q_in | input | 1 | Shared qualifier line, inbound side |
| trx_d_out | output | 12 | Shared data bus, outbound side |
| trx_q_out | output | 1 | Shared qualifier line, outbound side |
| trx_d_oe | output | 1 | Data bus driver enable |
| trx_q_oe | output | 1 | Qualifier driver enable |
| trx_clk_out | output | 1 | Shared clock line |
| txclk_pin_out | output | 1 | Dedicated transmit clock pin (two-clock arrangement) |
| tx_data | output | 12 | Word delivered to the transmit datapath |
| tx_qual | output | 1 | Qualifier delivered to the transmit datapath |
| dir_is_tx | output | 1 | Current direction, 1 = transmit |

## Verification
A direction change and the driver-enable update can fall in the same cycle. This happens when the register source flips `dir_is_tx` while receive data is still moving.

The bench provokes the coincidence in both directions. It checks the shared enables in the very cycle `dir_is_tx` toggles, and again one cycle later. In that same cycle it also checks that the shared clock line has already switched to the clock of the new direction.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
   typedef enum logic {
      DIR_RX = 1'b0,
      DIR_TX = 1'b1
   } hdx_dir_e;

   typedef enum logic {
      SRC_PIN = 1'b0,
      SRC_REG = 1'b1
   } hdx_src_e;
endpackage

// File: rtl/hdx_dir_ctrl.sv
module hdx_dir_ctrl
   import hdx_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dir_pin,
   input  logic src_sel,
   input  logic dir_reg,
   output logic dir_tx,
   output logic dir_turn
);
   localparam int LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("hdx_dir_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [LAST:0] sync_q;
   hdx_dir_e      dir_q, dir_prev_q;
   hdx_dir_e      dir_next;

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q[0] <= 1'b0;
            else        sync_q[0] <= dir_pin;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q[s] <= 1'b0;
            else        sync_q[s] <= sync_q[s-1];
      end
   end

   always_comb begin
      if (hdx_src_e'(src_sel) == SRC_REG) dir_next = hdx_dir_e'(dir_reg);
      else                                dir_next = hdx_dir_e'(sync_q[LAST]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q      <= DIR_RX;
         dir_prev_q <= DIR_RX;
      end else begin
         dir_q      <= dir_next;
         dir_prev_q <= dir_q;
      end
   end

   assign dir_tx   = (dir_q == DIR_TX);
   assign dir_turn = (dir_q != dir_prev_q);

   AST_REG_SRC_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel && !dir_turn) |=> (dir_tx == $past(dir_reg))) else $error("AST_REG_SRC_FOLLOW"); // R2

   AST_PIN_SRC_IGNORES_REG: assert property (@(posedge clk) disable iff (!rst_n)
      (!src_sel && !sync_q[LAST]) |=> !dir_tx) else $error("AST_PIN_SRC_IGNORES_REG"); // R3
endmodule

// File: rtl/hdx_lane_mux.sv
module hdx_lane_mux #(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dir_tx,
   input  logic              dir_turn,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_qual,
   input  logic [DATA_W-1:0] trx_d_in,
   input  logic              trx_q_in,
   output logic [DATA_W-1:0] trx_d_out,
   output logic              trx_q_out,
   output logic              trx_d_oe,
   output logic              trx_q_oe,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_qual
);
   if (DATA_W < 1) begin : g_bad_w
      $error("hdx_lane_mux: DATA_W must be positive");
   end

   logic [DATA_W-1:0] d_out_q;
   logic              q_out_q;
   logic              drive_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d_out_q <= '0;
         q_out_q <= 1'b0;
      end else begin
         d_out_q <= rx_data;
         q_out_q <= rx_qual;
      end
   end

   assign drive_en  = !dir_tx && !dir_turn;
   assign trx_d_oe  = drive_en;
   assign trx_q_oe  = drive_en;
   assign trx_d_out = d_out_q;
   assign trx_q_out = q_out_q;

   for (genvar b = 0; b < DATA_W; b++) begin : g_lane
      assign tx_data[b] = trx_d_in[b] & dir_tx;
   end
   assign tx_qual = trx_q_in & dir_tx;

   AST_OE_RX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (trx_d_oe || trx_q_oe) |-> !dir_tx) else $error("AST_OE_RX_ONLY"); // R6

   AST_OE_DROP_AT_TURN: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_tx != $past(dir_tx)) |-> (!trx_d_oe && !trx_q_oe)) else $error("AST_OE_DROP_AT_TURN"); // R6

   AST_TX_QUIET_IN_RX: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_tx |-> (tx_data == '0 && !tx_qual)) else $error("AST_TX_QUIET_IN_RX"); // R5

   AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (trx_d_out == $past(rx_data))) else $error("AST_RX_ONE_CYCLE"); // R4
endmodule

// File: rtl/hdx_clk_route.sv
module hdx_clk_route #(
   parameter bit ALLOW_TWO_CLK = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dir_tx,
   input  logic two_clk,
   input  logic keep_on,
   input  logic rx_clk_src,
   input  logic tx_clk_src,
   output logic trx_clk_out,
   output logic txclk_pin_out
);
   logic rx_run, tx_run;
   logic rx_gated, tx_gated;
   logic two_mode;

   assign rx_run   = !dir_tx || keep_on;
   assign tx_run   =  dir_tx || keep_on;
   assign rx_gated = rx_clk_src & rx_run;
   assign tx_gated = tx_clk_src & tx_run;

   if (ALLOW_TWO_CLK) begin : g_two_ok
      assign two_mode = two_clk;
   end else begin : g_one_only
      logic unused_two;
      assign unused_two = two_clk;
      assign two_mode   = 1'b0;
   end

   always_comb begin
      if (two_mode) begin
         trx_clk_out   = rx_gated;
         txclk_pin_out = tx_gated;
      end else begin
         trx_clk_out   = dir_tx ? tx_gated : rx_gated;
         txclk_pin_out = 1'b0;
      end
   end

   AST_ONECLK_TXPIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !two_clk |-> !txclk_pin_out) else $error("AST_ONECLK_TXPIN_LOW"); // R7

   AST_TWOCLK_NO_TX_ON_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
      (two_mode && !rx_clk_src) |-> !trx_clk_out) else $error("AST_TWOCLK_NO_TX_ON_SHARED"); // R8

   AST_GATE_IDLE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (!keep_on && two_mode) |-> !(dir_tx ? trx_clk_out : txclk_pin_out)) else $error("AST_GATE_IDLE_DIR"); // R9

   AST_KEEP_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      (keep_on && two_mode) |-> (trx_clk_out == rx_clk_src && txclk_pin_out == tx_clk_src)) else $error("AST_KEEP_RUNS"); // R10
endmodule

// File: rtl/hdx_port_mux.sv
module hdx_port_mux
   import hdx_pkg::*;
#(
   parameter int DATA_W        = 12,
   parameter int SYNC_STAGES   = 2,
   parameter bit ALLOW_TWO_CLK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dir_pin,
   input  logic              cfg_dir_src,
   input  logic              cfg_dir_tx,
   input  logic              cfg_two_clk,
   input  logic              cfg_clk_keep,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_qual,
   input  logic              rx_clk_src,
   input  logic              tx_clk_src,
   input  logic [DATA_W-1:0] trx_d_in,
   input  logic              trx_q_in,
   output logic [DATA_W-1:0] trx_d_out,
   output logic              trx_q_out,
   output logic              trx_d_oe,
   output logic              trx_q_oe,
   output logic              trx_clk_out,
   output logic              txclk_pin_out,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_qual,
   output logic              dir_is_tx
);
   logic dir_tx_w, dir_turn_w;

   hdx_dir_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_dir (
      .clk      (clk),
      .rst_n    (rst_n),
      .dir_pin  (dir_pin),
      .src_sel  (cfg_dir_src),
      .dir_reg  (cfg_dir_tx),
      .dir_tx   (dir_tx_w),
      .dir_turn (dir_turn_w)
   );

   hdx_lane_mux #(.DATA_W(DATA_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .dir_tx    (dir_tx_w),
      .dir_turn  (dir_turn_w),
      .rx_data   (rx_data),
      .rx_qual   (rx_qual),
      .trx_d_in  (trx_d_in),
      .trx_q_in  (trx_q_in),
      .trx_d_out (trx_d_out),
      .trx_q_out (trx_q_out),
      .trx_d_oe  (trx_d_oe),
      .trx_q_oe  (trx_q_oe),
      .tx_data   (tx_data),
      .tx_qual   (tx_qual)
   );

   hdx_clk_route #(.ALLOW_TWO_CLK(ALLOW_TWO_CLK)) u_clk (
      .clk           (clk),
      .rst_n         (rst_n),
      .dir_tx        (dir_tx_w),
      .two_clk       (cfg_two_clk),
      .keep_on       (cfg_clk_keep),
      .rx_clk_src    (rx_clk_src),
      .tx_clk_src    (tx_clk_src),
      .trx_clk_out   (trx_clk_out),
      .txclk_pin_out (txclk_pin_out)
   );

   assign dir_is_tx = dir_tx_w;

   AST_RESET_RX: assert property (@(posedge clk) $rose(rst_n) |-> (!dir_is_tx && trx_d_oe)) else $error("AST_RESET_RX"); // R1
endmodule

// File: tb/hdx_port_mux_bench.sv
module hdx_port_mux_bench;
   localparam int  W      = 12;
   localparam int  VW     = 3 + W + 1 + W + 1 + 2;
   localparam time CLK_HP = 5ns;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dir_pin = 1'b0, cfg_dir_src = 1'b1, cfg_dir_tx = 1'b0;
   logic cfg_two_clk = 1'b0, cfg_clk_keep = 1'b0;
   logic [W-1:0] rx_data = '0, trx_d_in = '0;
   logic rx_qual = 1'b0, trx_q_in = 1'b0;
   logic rx_clk_src = 1'b1, tx_clk_src = 1'b1;
   logic [W-1:0] trx_d_out, tx_data;
   logic trx_q_out, trx_d_oe, trx_q_oe, trx_clk_out, txclk_pin_out, tx_qual, dir_is_tx;

   hdx_port_mux u_hdx_port_mux (.*);

   always #CLK_HP clk = ~clk;

   typedef struct {
      int            at;
      string         req;
      logic [VW-1:0] exp;
   } item_t;

   item_t sb[$];
   int cyc = 0, total = 0, bad = 0;
   bit done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: pops expected items and compares them at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         while (sb.size() > 0 && sb[0].at <= cyc) begin
            item_t it;
            logic [VW-1:0] obs;
            it  = sb.pop_front();
            obs = {dir_is_tx, trx_d_oe, trx_q_oe, trx_d_out, trx_q_out,
                   tx_data, tx_qual, trx_clk_out, txclk_pin_out};
            total++;
            if (it.at != cyc || obs !== it.exp) begin
               bad++;
               $display("FAIL %s cyc=%0d got=%h exp=%h", it.req, cyc, obs, it.exp);
            end
         end
      end
   end

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic push(int off, string r, logic dir, logic oe, logic [W-1:0] dout,
                       logic qo, logic [W-1:0] txd, logic txq, logic ck, logic tp);
      item_t it;
      it.at  = cyc + off;
      it.req = r;
      it.exp = {dir, oe, oe, dout, qo, txd, txq, ck, tp};
      sb.push_back(it);
   endtask

   initial begin
      #(CLK_HP * 40000);
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state, one-clock receive
      push(0, "R1", 0, 1, 12'h000, 0, 12'h000, 0, 1, 0);
      tick(1);

      // R4 receive data registered one cycle; R5 inbound bus ignored in receive
      rx_data = 12'hA5C; rx_qual = 1'b1; trx_d_in = 12'hFFF; trx_q_in = 1'b1;
      rx_clk_src = 1'b1; tx_clk_src = 1'b0;
      push(0, "R4", 0, 1, 12'h000, 0, 12'h000, 0, 1, 0);
      push(1, "R4_R5", 0, 1, 12'hA5C, 1, 12'h000, 0, 1, 0);
      tick(1);

      // R2 register source to transmit; R6 enables drop in the turn cycle; R7 clock swap
      cfg_dir_tx = 1'b1;
      tick(1);
      push(0, "R2_R6_R7", 1, 0, 12'hA5C, 1, 12'hFFF, 1, 0, 0);
      tick(1);
      trx_d_in = 12'h3C3; trx_q_in = 1'b0; rx_clk_src = 1'b0; tx_clk_src = 1'b1;
      push(0, "R5_R7", 1, 0, 12'hA5C, 1, 12'h3C3, 0, 1, 0);
      tick(1);

      // back to receive: enables low one cycle, then high (R6)
      cfg_dir_tx = 1'b0; rx_clk_src = 1'b1; tx_clk_src = 1'b0; rx_data = 12'h123; rx_qual = 1'b0;
      tick(1);
      push(0, "R6_turn_rx", 0, 0, 12'h123, 0, 12'h000, 0, 1, 0);
      push(1, "R6_after", 0, 1, 12'h123, 0, 12'h000, 0, 1, 0);
      tick(2);

      // R3 pin source, register bit ignored, three edges of latency
      cfg_dir_src = 1'b0; dir_pin = 1'b1; cfg_dir_tx = 1'b1;
      push(1, "R3_ignore_reg", 0, 1, 12'h123, 0, 12'h000, 0, 1, 0);
      push(2, "R3_latency", 0, 1, 12'h123, 0, 12'h000, 0, 1, 0);
      push(3, "R3_follow", 1, 0, 12'h123, 0, 12'h3C3, 0, 0, 0);
      tick(4);
      dir_pin = 1'b0;
      push(2, "R3_hold", 1, 0, 12'h123, 0, 12'h3C3, 0, 0, 0);
      push(3, "R3_back", 0, 0, 12'h123, 0, 12'h000, 0, 1, 0);
      tick(5);

      // R8 two-clock in receive: tx clock pin gated (R9)
      cfg_dir_src = 1'b1; cfg_dir_tx = 1'b0; cfg_two_clk = 1'b1;
      rx_clk_src = 1'b1; tx_clk_src = 1'b1;
      tick(1);
      push(0, "R8_R9_rx", 0, 1, 12'h123, 0, 12'h000, 0, 1, 0);
      tick(1);
      cfg_dir_tx = 1'b1;
      tick(2);
      push(0, "R8_R9_tx", 1, 0, 12'h123, 0, 12'h3C3, 0, 0, 1);
      tick(1);

      // R10 keep both clocks running
      cfg_clk_keep = 1'b1;
      push(0, "R10_tx", 1, 0, 12'h123, 0, 12'h3C3, 0, 1, 1);
      tick(1);
      cfg_dir_tx = 1'b0;
      tick(2);
      push(0, "R10_rx", 0, 1, 12'h123, 0, 12'h000, 0, 1, 1);
      tick(1);
      cfg_two_clk = 1'b0; rx_clk_src = 1'b0; tx_clk_src = 1'b1;
      push(0, "R10_R7_oneclk", 0, 1, 12'h123, 0, 12'h000, 0, 0, 0);
      tick(3);

      if (sb.size() != 0) begin
         bad++;
         $display("FAIL scoreboard left=%0d exp=0", sb.size());
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule